// File: doc/BRIEF.md
# Byte-Accessed Bidirectional Tick Counter

This block is a 16-bit counter that runs up or down on tick pulses from an external clock-select stage. Software reaches it over an 8-bit register bus. The counter's upper byte is never read or written directly. Every bus access to the upper location goes to an 8-bit holding register instead.

Reading the lower location latches the counter's current upper byte into the holding register. Writing the lower location commits the holding register and the new lower byte to the counter in one cycle. As a result, software sees a coherent 16-bit snapshot when it reads low then high, and a 16-bit value loads atomically when it writes high then low. This holds even while ticks keep arriving between the two accesses.

The block also produces three outputs:
- a flag for a counter value of zero;
- a flag for a match with a supplied top value;
- a one-cycle wrap pulse, backed by a sticky status bit that software clears by writing a one.

Top module: `wide_tick_counter`

## Requirements
- R1: A synchronous active-high reset clears the counter, the holding register, the sticky wrap bit, the read-data register and the wrap pulse to zero.
- R2: A bus write to location 1 loads only the holding register and leaves the counter unchanged. A bus read of location 1 returns the holding register.
- R3: A bus read of location 0 returns the counter's low byte. At the same edge it copies the counter's high byte into the holding register, so a following read of location 1 returns the high byte as it was at the low-byte read, even if ticks arrive in between.
- R4: A bus write to location 0 loads the counter with {holding register, write data} in a single edge.
- R5: On an enabled tick the counter becomes zero when clear is high. Otherwise it adds one when the direction input is 0, or subtracts one when the direction input is 1. Clear takes precedence over direction.
- R6: While the 3-bit clock-select field is 0, ticks are ignored and the counter holds its value. Bus reads and writes work normally in this state.
- R7: A bus write to location 0 takes priority over a clear, increment or decrement that falls on the same edge.
- R8: The bottom flag is high exactly when the counter is zero. The top flag is high exactly when the counter equals the 16-bit top-value input, which is normally 0xFFFF.
- R9: The wrap pulse is high for one cycle after a tick that takes the counter from 0xFFFF to 0x0000 (counting up) or from 0x0000 to 0xFFFF (counting down). The same edge sets the sticky wrap bit, which is read as bit 0 of location 2. Writing location 2 with bit 0 set clears the sticky bit, but a wrap on the same edge wins over the clear.
- R10: Read data is registered and appears the cycle after the read strobe. It holds its value when no read strobe is present. Location 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable tick from the clock-select stage |
| clk_sel_i | input | 3 | Clock-select field; 0 blocks all ticks |
| dir_down_i | input | 1 | 0 = count up, 1 = count down |
| clear_i | input | 1 | Zero the counter on the next enabled tick |
| top_val_i | input | 16 | Value compared for the top flag |
| bus_addr_i | input | 2 | 0 low byte, 1 holding byte, 2 status, 3 unused |
| bus_we_i | input | 1 | Bus write enable |
| bus_re_i | input | 1 | Bus read strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Registered bus read data |
| top_o | output | 1 | Counter equals top value |
| bottom_o | output | 1 | Counter equals zero |
| ovf_irq_o | output | 1 | One-cycle wrap pulse |

## Verification
The counter is driven in four ways:
- Straight up-counting and down-counting runs separate the direction logic from the clear path.
- Runs through 0xFFFF and 0x0000 with writes landing on tick edges expose mistakes in wrap detection and in write-over-tick priority.
- Low-then-high reads made while ticks continue show whether the high byte is frozen at the low-byte read or leaks a later value.
- A long random mix of ticks, clock-select values, reads, writes and status clears, checked every cycle against a behavioural model, catches interactions the directed runs miss, such as a clear and a wrap landing on the same edge.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    LOC_LOW  = 2'd0,
    LOC_HOLD = 2'd1,
    LOC_STAT = 2'd2,
    LOC_NONE = 2'd3
  } loc_e;
endpackage

// File: rtl/wtc_bus_port.sv
module wtc_bus_port
  import wtc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic                bus_re_i,
  input  logic [BYTE_W-1:0]   bus_wdata_i,
  input  logic [2*BYTE_W-1:0] cnt_i,
  input  logic                flag_i,
  output logic [BYTE_W-1:0]   hold_o,
  output logic                load_o,
  output logic                flag_clr_o,
  output logic [BYTE_W-1:0]   rdata_o
);
  loc_e loc;
  logic [BYTE_W-1:0] hold_q, rdata_q;

  always_comb loc = loc_e'(bus_addr_i);

  assign load_o     = bus_we_i && (loc == LOC_LOW);
  assign flag_clr_o = bus_we_i && (loc == LOC_STAT) && bus_wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (bus_we_i && loc == LOC_HOLD) begin
      hold_q <= bus_wdata_i;
    end else if (bus_re_i && loc == LOC_LOW) begin
      hold_q <= cnt_i[2*BYTE_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_re_i) begin
      unique case (loc)
        LOC_LOW:  rdata_q <= cnt_i[BYTE_W-1:0];
        LOC_HOLD: rdata_q <= hold_q;
        LOC_STAT: rdata_q <= {{(BYTE_W-1){1'b0}}, flag_i};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign hold_o  = hold_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wtc_core.sv
module wtc_core #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en_i,
  input  logic             dir_down_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = tick_en_i && !load_i && !clear_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_en_i) begin
      if (clear_i)         cnt_d = '0;
      else if (dir_down_i) cnt_d = cnt_q - ONE;
      else                 cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign wrap_o = step && (dir_down_i ? (cnt_q == '0) : (cnt_q == FULL));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wtc_status.sv
module wtc_status #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] top_val_i,
  input  logic             wrap_i,
  input  logic             flag_clr_i,
  output logic             top_o,
  output logic             bottom_o,
  output logic             pulse_o,
  output logic             flag_o
);
  logic pulse_q, flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= wrap_i;
      if (wrap_i)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign top_o    = (cnt_i == top_val_i);
  assign bottom_o = (cnt_i == '0);
  assign pulse_o  = pulse_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/wide_tick_counter.sv
module wide_tick_counter
  import wtc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic              dir_down_i,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  top_val_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              top_o,
  output logic              bottom_o,
  output logic              ovf_irq_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] hold_q;
  logic              load, flag_clr, wrap, ovf_flag_q, tick_en;

  assign tick_en = tick_i && (clk_sel_i != '0);

  wtc_bus_port #(.BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst(rst),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_re_i(bus_re_i),
    .bus_wdata_i(bus_wdata_i), .cnt_i(cnt_q), .flag_i(ovf_flag_q),
    .hold_o(hold_q), .load_o(load), .flag_clr_o(flag_clr),
    .rdata_o(bus_rdata_o)
  );

  wtc_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst(rst),
    .tick_en_i(tick_en), .dir_down_i(dir_down_i), .clear_i(clear_i),
    .load_i(load), .load_val_i({hold_q, bus_wdata_i}),
    .cnt_o(cnt_q), .wrap_o(wrap)
  );

  wtc_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst(rst),
    .cnt_i(cnt_q), .top_val_i(top_val_i),
    .wrap_i(wrap), .flag_clr_i(flag_clr),
    .top_o(top_o), .bottom_o(bottom_o),
    .pulse_o(ovf_irq_o), .flag_o(ovf_flag_q)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic [SEL_W-1:0]  clk_sel_i,
  input logic              dir_down_i,
  input logic              clear_i,
  input logic [1:0]        bus_addr_i,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [BYTE_W-1:0] bus_wdata_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [BYTE_W-1:0] hold_q,
  input logic              ovf_irq_o,
  input logic              ovf_flag_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic wr_low, ticking;
  assign wr_low  = bus_we_i && bus_addr_i == 2'd0;
  assign ticking = tick_i && clk_sel_i != '0 && !wr_low;

  // R3: a low-byte read latches the counter's high byte
  a_r3_snapshot: assert property (@(posedge clk) disable iff (rst)
    (bus_re_i && bus_addr_i == 2'd0 && !(bus_we_i && bus_addr_i == 2'd1))
      |=> hold_q == $past(cnt_q[CNT_W-1:BYTE_W]));

  // R4 / R7: a low-byte write commits holding register and data, ignoring ticks
  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    wr_low |=> cnt_q == {$past(hold_q), $past(bus_wdata_i)});

  // R5: an enabled upward tick without clear adds one
  a_r5_increment: assert property (@(posedge clk) disable iff (rst)
    (ticking && !clear_i && !dir_down_i) |=> $past(cnt_q) == cnt_q - ONE);

  // R5: an enabled tick with clear zeroes the counter
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (ticking && clear_i) |=> cnt_q == '0);

  // R6: with clock select at 0 and no load, the counter holds
  a_r6_gated: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_i == '0 && !wr_low) |=> $stable(cnt_q));

  // R9: a wrap pulse always coincides with the sticky bit being set
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_irq_o |-> ovf_flag_q);
endmodule

bind wide_tick_counter wtc_checker #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .clk_sel_i(clk_sel_i),
  .dir_down_i(dir_down_i), .clear_i(clear_i), .bus_addr_i(bus_addr_i),
  .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .bus_wdata_i(bus_wdata_i),
  .cnt_q(cnt_q), .hold_q(hold_q), .ovf_irq_o(ovf_irq_o), .ovf_flag_q(ovf_flag_q)
);

// File: tb/wide_tick_counter_bench.sv
`timescale 1ns/1ps
module wide_tick_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 0, dir_down_i = 0, clear_i = 0;
  logic [2:0]  clk_sel_i = 0;
  logic [15:0] top_val_i = 16'hFFFF;
  logic [1:0]  bus_addr_i = 0;
  logic        bus_we_i = 0, bus_re_i = 0;
  logic [7:0]  bus_wdata_i = 0;
  logic [7:0]  bus_rdata_o;
  logic        top_o, bottom_o, ovf_irq_o;

  int vectors = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0, m_hold = 0, m_rdata = 0;
  bit m_flag = 0, m_pulse = 0;

  always #2.5 clk = ~clk;

  wide_tick_counter u_wide_tick_counter (.*);

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int nc = m_cnt, nh = m_hold, nr = m_rdata;
    bit en, wrap;
    if (rst) begin
      m_cnt = 0; m_hold = 0; m_rdata = 0; m_flag = 0; m_pulse = 0;
      return;
    end
    en = tick_i && clk_sel_i != 0;
    wrap = 0;
    if (bus_re_i)
      case (bus_addr_i)
        0: nr = m_cnt % 256;
        1: nr = m_hold;
        2: nr = m_flag;
        default: nr = 0;
      endcase
    if (bus_we_i && bus_addr_i == 1) nh = bus_wdata_i;
    else if (bus_re_i && bus_addr_i == 0) nh = m_cnt / 256;
    if (bus_we_i && bus_addr_i == 0) nc = m_hold * 256 + bus_wdata_i;
    else if (en) begin
      if (clear_i) nc = 0;
      else if (dir_down_i) begin wrap = (m_cnt == 0); nc = (m_cnt + 65535) % 65536; end
      else begin wrap = (m_cnt == 65535); nc = (m_cnt + 1) % 65536; end
    end
    m_pulse = wrap;
    if (wrap) m_flag = 1;
    else if (bus_we_i && bus_addr_i == 2 && bus_wdata_i[0]) m_flag = 0;
    m_cnt = nc; m_hold = nh; m_rdata = nr;
  endtask

  // one clock: inputs already set at negedge; model on posedge; compare at next negedge
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "rdata", bus_rdata_o, m_rdata);
    check(tag, "bottom", bottom_o, m_cnt == 0);
    check(tag, "top", top_o, m_cnt == top_val_i);
    check(tag, "ovf", ovf_irq_o, m_pulse);
  endtask

  task automatic idle();
    tick_i = 0; clear_i = 0; bus_we_i = 0; bus_re_i = 0;
  endtask

  task automatic bus_wr(string tag, int a, int d);
    bus_addr_i = 2'(a); bus_wdata_i = 8'(d); bus_we_i = 1; cyc(tag); bus_we_i = 0;
  endtask

  task automatic bus_rd(string tag, int a, int exp);
    bus_addr_i = 2'(a); bus_re_i = 1; cyc(tag); bus_re_i = 0;
    check(tag, "read value", bus_rdata_o, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; cyc("R1"); cyc("R1");
    rst = 0;
    bus_rd("R1", 2, 0);
    check("R1", "bottom after reset", bottom_o, 1);

    // R2: high write only touches holding register
    bus_wr("R2", 1, 8'h12);
    check("R2", "counter untouched", bottom_o, 1);
    bus_rd("R2", 1, 8'h12);

    // R4: atomic load
    bus_wr("R4", 0, 8'h34);
    bus_rd("R4", 0, 8'h34);
    bus_rd("R4", 1, 8'h12);

    // R5 up counting, R8 top match
    top_val_i = 16'h1238;
    clk_sel_i = 3'd1; tick_i = 1; dir_down_i = 0;
    repeat (4) cyc("R5");
    tick_i = 0;
    check("R8", "top at match", top_o, 1);
    top_val_i = 16'hFFFF;

    // R3: snapshot while ticking across a byte carry
    bus_wr("R3", 1, 8'h20); bus_wr("R3", 0, 8'hFE);
    tick_i = 1;
    bus_rd("R3", 0, 8'hFE);
    repeat (3) cyc("R3");
    bus_rd("R3", 1, 8'h20);
    tick_i = 0;

    // R5 down and clear precedence
    dir_down_i = 1; tick_i = 1; repeat (3) cyc("R5");
    clear_i = 1; cyc("R5"); clear_i = 0; tick_i = 0;
    check("R5", "cleared", bottom_o, 1);

    // R6: gated ticks, bus still live
    bus_wr("R6", 1, 8'h40); bus_wr("R6", 0, 8'h01);
    clk_sel_i = 0; tick_i = 1; dir_down_i = 0;
    repeat (5) cyc("R6");
    bus_rd("R6", 0, 8'h01);
    bus_rd("R6", 1, 8'h40);
    tick_i = 0; clk_sel_i = 3'd3;

    // R9: upward wrap, sticky bit, W1C
    bus_wr("R9", 1, 8'hFF); bus_wr("R9", 0, 8'hFF);
    check("R8", "top at FFFF", top_o, 1);
    tick_i = 1; cyc("R9"); tick_i = 0;
    check("R9", "pulse on up wrap", ovf_irq_o, 1);
    cyc("R9");
    check("R9", "pulse one cycle", ovf_irq_o, 0);
    bus_rd("R9", 2, 1);
    bus_wr("R9", 2, 8'h01);
    bus_rd("R9", 2, 0);
    // downward wrap with clear-write on same edge: set wins
    dir_down_i = 1; tick_i = 1; bus_addr_i = 2; bus_wdata_i = 1; bus_we_i = 1;
    cyc("R9"); idle();
    check("R9", "pulse on down wrap", ovf_irq_o, 1);
    bus_rd("R9", 2, 1);
    bus_wr("R9", 2, 8'h01);

    // R7: load beats tick and clear on the same edge
    bus_wr("R7", 1, 8'hAB);
    tick_i = 1; clear_i = 1; bus_addr_i = 0; bus_wdata_i = 8'hCD; bus_we_i = 1;
    cyc("R7"); idle();
    bus_rd("R7", 0, 8'hCD);
    bus_rd("R7", 1, 8'hAB);

    // R10: location 3 reads zero; read data holds without strobe
    bus_rd("R10", 3, 0);
    bus_addr_i = 0; repeat (2) cyc("R10");
    check("R10", "rdata held", bus_rdata_o, 0);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      tick_i      = ($urandom % 4) != 0;
      clk_sel_i   = ($urandom % 5 == 0) ? 3'd0 : 3'($urandom);
      dir_down_i  = ($urandom % 8) < 3;
      clear_i     = ($urandom % 20) == 0;
      bus_addr_i  = 2'($urandom);
      bus_re_i    = ($urandom % 3) == 0;
      bus_we_i    = ($urandom % 6) == 0;
      bus_wdata_i = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
      top_val_i   = ($urandom % 2) ? 16'hFFFF : 16'(m_cnt);
      cyc("R10");
    end
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule